// File: doc/BRIEF.md
# Paired-Channel PWM Tick Divider

This block produces the counting tick enables for a bank of PWM channels that are grouped in pairs. Each pair owns one configuration word that picks one of two source strobes (an oscillator-rate strobe or a bus-rate strobe) and a power-of-two divide exponent. Both channels of a pair therefore always count at the same rate. Each channel then applies its own enable bit, which can silence its tick. It also has its own bypass bit, which passes the undivided source strobe straight through.

The two source clocks are modelled as single-cycle enable strobes in the one main clock domain, so the whole block is single-clock. Its outputs are one registered tick enable per channel, which the downstream period counter of that channel consumes. Software programs the configuration words and the enable/bypass register through a plain write port. A write to a pair's configuration word restarts that pair's divider from zero.

Top module: `pwm_pair_tick_gen`

## Requirements
- R1: Channels 2i and 2i+1 both take their source and exponent from the configuration word at write address i. A write to another pair's address leaves them unchanged.
- R2: In a configuration word, bits [8:7] hold the source field and bits [3:0] hold the divide exponent. All other data bits are ignored.
- R3: A source field of 0 selects `osc_tick`. Any nonzero source field (01, 10 or 11) selects `bus_tick`. Strobes on the unselected input have no effect and are not counted.
- R4: With exponent m, the pair emits one divided tick on every 2^m-th selected strobe after a restart. An exponent above 8 behaves exactly like 8 (one tick per 256 strobes).
- R5: The enable register sits at write address 16, with channel n's enable at data bit n. While that bit is 0, `tick_o[n]` stays 0.
- R6: Channel n's bypass sits at bit n+16 of the same register. When both its enable and bypass are 1, `tick_o[n]` pulses on every selected strobe and the exponent is ignored.
- R7: A write to a pair's configuration word restarts its divider from zero. A selected strobe in the same cycle as that write is neither counted nor able to produce a divided tick.
- R8: `tick_o` is registered. A strobe sampled at a rising edge shows on `tick_o` directly after that edge, for exactly one cycle.
- R9: Synchronous reset clears all configuration words and all enable and bypass bits, and drives `tick_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator-rate source strobe |
| bus_tick | input | 1 | Bus-rate source strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Write address: pair index, or 16 for enable/bypass |
| wr_data | input | 32 | Write data |
| tick_o | output | NUM_CH (8) | Per-channel tick enable |

## Verification
A configuration write to a pair and a selected source strobe can land in the same cycle. In that cycle the restart and the count advance both try to change the divider. The bench first runs the divider part-way through a count. It then raises `wr_en` to the pair's address together with `osc_tick` in one cycle. The result is judged at the port. No tick may appear in the colliding cycle, and the next divided tick must arrive only on the fourth fresh strobe, not on the second, which is where it would fall had the count survived.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int DATA_W  = 32;
  localparam int SRC_W   = 2;
  localparam int SRC_LSB = 7;
  localparam int EXP_W   = 4;
  localparam int EXP_LSB = 0;
  localparam int BYP_OFS = 16;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [EXP_W-1:0] expo;
  } pair_cfg_t;
endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs
  import pwm_tick_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int ADDR_W    = 5,
  parameter int GATE_ADDR = 16,
  localparam int NPAIR    = NUM_CH / 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output pair_cfg_t [NPAIR-1:0]  cfg_o,
  output logic [NPAIR-1:0]       cfg_wr_o,
  output logic [NUM_CH-1:0]      gate_o,
  output logic [NUM_CH-1:0]      byp_o
);
  logic [NUM_CH-1:0] gate_q, byp_q;
  logic              gate_sel;

  assign gate_sel = wr_en && (wr_addr == ADDR_W'(GATE_ADDR));

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pair_cfg_t cfg_q;
    assign cfg_wr_o[p] = wr_en && (wr_addr == ADDR_W'(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q <= '0;
      end else if (cfg_wr_o[p]) begin
        cfg_q.src  <= wr_data[SRC_LSB +: SRC_W];
        cfg_q.expo <= wr_data[EXP_LSB +: EXP_W];
      end
    end
    assign cfg_o[p] = cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      byp_q  <= '0;
    end else if (gate_sel) begin
      gate_q <= wr_data[NUM_CH-1:0];
      byp_q  <= wr_data[BYP_OFS +: NUM_CH];
    end
  end

  assign gate_o = gate_q;
  assign byp_o  = byp_q;

  // R9: reset leaves every enable and bypass bit cleared
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (gate_q == '0 && byp_q == '0));
endmodule

// File: rtl/pt_pair_div.sv
module pt_pair_div
  import pwm_tick_pkg::*;
#(
  parameter int MAX_EXP = 8,
  localparam int CNT_W  = (MAX_EXP < 1) ? 1 : MAX_EXP
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      osc_tick,
  input  logic      bus_tick,
  input  pair_cfg_t cfg_i,
  input  logic      cfg_wr_i,
  output logic      sel_stb_o,
  output logic      div_stb_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [EXP_W-1:0] eff_exp;
  logic [CNT_W:0]   term;
  logic             at_term;

  assign sel_stb_o = (cfg_i.src != '0) ? bus_tick : osc_tick;
  assign eff_exp   = (cfg_i.expo > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : cfg_i.expo;
  assign term      = ((CNT_W+1)'(1) << eff_exp) - (CNT_W+1)'(1);
  assign at_term   = ({1'b0, cnt_q} == term);
  assign div_stb_o = sel_stb_o && at_term && !cfg_wr_i;

  always_ff @(posedge clk) begin
    if (rst || cfg_wr_i) begin
      cnt_q <= '0;
    end else if (sel_stb_o) begin
      cnt_q <= at_term ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R4: count never passes the terminal value of the clamped exponent
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_q} <= term));
  // R7: a configuration write restarts the count
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_i |=> (cnt_q == '0));
  // R3: count only moves on a selected strobe or a restart
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!sel_stb_o && !cfg_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pt_chan_tick.sv
module pt_chan_tick (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  input  logic byp_i,
  input  logic sel_stb_i,
  input  logic div_stb_i,
  output logic tick_o
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= gate_i && (byp_i ? sel_stb_i : div_stb_i);
  end

  assign tick_o = tick_q;

  // R5: a disabled channel emits nothing
  p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
    !gate_i |=> !tick_o);
  // R6: bypass passes every selected strobe
  p_bypass_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (gate_i && byp_i && sel_stb_i) |=> tick_o);
  // R8: a tick is always one cycle after a selected strobe
  p_tick_after_stb_r8: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(sel_stb_i));
endmodule

// File: rtl/pwm_pair_tick_gen.sv
module pwm_pair_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int MAX_EXP   = 8,
  parameter int ADDR_W    = 5,
  parameter int GATE_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              bus_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NUM_CH-1:0] tick_o
);
  localparam int NPAIR = NUM_CH / 2;

  pair_cfg_t [NPAIR-1:0] cfg;
  logic [NPAIR-1:0]      cfg_wr;
  logic [NPAIR-1:0]      sel_stb, div_stb;
  logic [NUM_CH-1:0]     gate, byp;

  pt_cfg_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .GATE_ADDR(GATE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_o(cfg), .cfg_wr_o(cfg_wr), .gate_o(gate), .byp_o(byp)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_div
    pt_pair_div #(.MAX_EXP(MAX_EXP)) u_div (
      .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_tick(bus_tick),
      .cfg_i(cfg[p]), .cfg_wr_i(cfg_wr[p]),
      .sel_stb_o(sel_stb[p]), .div_stb_o(div_stb[p])
    );
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    pt_chan_tick u_chan (
      .clk(clk), .rst(rst), .gate_i(gate[n]), .byp_i(byp[n]),
      .sel_stb_i(sel_stb[n/2]), .div_stb_i(div_stb[n/2]), .tick_o(tick_o[n])
    );
  end

  // R1: both channels of a pair share one divided tick when both are plain-enabled
  p_pair_match_r1: assert property (@(posedge clk) disable iff (rst)
    (gate[0] && gate[1] && !byp[0] && !byp[1]) |=> (tick_o[0] == tick_o[1]));
endmodule

// File: tb/pwm_pair_tick_gen_bench.sv
module pwm_pair_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_tick = 1'b0, bus_tick = 1'b0, wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  tick_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_pair_tick_gen u_pwm_pair_tick_gen (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_tick(bus_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tick_o(tick_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // write one register; inputs change at the falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // one strobe cycle; returns tick_o right after the edge that sampled it
  task automatic stb(input logic o, input logic b, output logic [7:0] t);
    osc_tick = o; bus_tick = b;
    @(posedge clk); @(negedge clk);
    t = tick_o;
    osc_tick = 1'b0; bus_tick = 1'b0;
  endtask

  // n strobes on one input; channel ch ticks on every per-th
  task automatic run_div(input int n, input bit use_bus, input int ch, input int per,
                         input string req);
    logic [7:0] t;
    for (int i = 0; i < n; i++) begin
      stb(!use_bus, use_bus, t);
      check(t[ch] == (((i + 1) % per) == 0), req, t[ch], (((i + 1) % per) == 0));
    end
  endtask

  task automatic t_reset();
    logic [7:0] t;
    check(tick_o == 8'h00, "R9 reset output", tick_o, 0);
    stb(1'b1, 1'b1, t);
    check(t == 8'h00, "R9 gates cleared by reset", t, 0);
  endtask

  task automatic t_osc_ratio();
    logic [7:0] t;
    wr(5'd16, 32'h0000_0001);
    wr(5'd0, 32'h0000_0002);            // src 0, exponent 2
    // R3: bus strobes are not counted while oscillator selected
    for (int i = 0; i < 3; i++) begin
      stb(1'b0, 1'b1, t);
      check(t[0] == 1'b0, "R3 unselected bus ignored", t[0], 0);
    end
    run_div(12, 1'b0, 0, 4, "R4 R8 divide by 4 on osc");
  endtask

  task automatic t_bus_pair();
    logic [7:0] t;
    wr(5'd16, 32'h0000_000C);            // enable ch2, ch3
    wr(5'd1, 32'h0000_0101);             // src 10 (bit 8), exponent 1
    for (int i = 0; i < 6; i++) begin
      stb(1'b0, 1'b1, t);
      check(t[2] == (i % 2 == 1), "R1 R3 ch2 bus div2", t[2], (i % 2 == 1));
      check(t[3] == t[2], "R1 pair partner ch3", t[3], t[2]);
    end
    stb(1'b1, 1'b0, t);
    check(t[3:2] == 2'b00, "R3 osc ignored when bus selected", t[3:2], 0);
    wr(5'd1, 32'h0000_0080);             // src 01 also selects bus, exponent 0
    stb(1'b0, 1'b1, t);
    check(t[2] == 1'b1, "R3 src 01 selects bus", t[2], 1);
    wr(5'd0, 32'h0000_0003);             // other pair's word
    stb(1'b0, 1'b1, t);
    check(t[2] == 1'b1, "R1 other pair write no effect", t[2], 1);
  endtask

  task automatic t_clamp();
    wr(5'd16, 32'h0000_0001);
    wr(5'd0, 32'h0000_000F);             // exponent 15 -> 8
    run_div(512, 1'b0, 0, 256, "R4 exponent 15 clamps to 8");
    wr(5'd0, 32'h0000_0008);
    run_div(256, 1'b0, 0, 256, "R4 exponent 8");
  endtask

  task automatic t_fields();
    wr(5'd16, 32'h0000_0001);
    wr(5'd0, 32'hFFFF_FE71);             // junk outside [8:7],[3:0]; src 0, exp 1
    run_div(6, 1'b0, 0, 2, "R2 extra bits ignored");
  endtask

  task automatic t_bypass();
    logic [7:0] t;
    wr(5'd16, 32'h0002_0003);            // enable ch0, ch1; bypass ch1
    wr(5'd0, 32'h0000_0003);             // exponent 3
    for (int i = 0; i < 16; i++) begin
      stb(1'b1, 1'b0, t);
      check(t[1] == 1'b1, "R6 bypass ticks every strobe", t[1], 1);
      check(t[0] == (((i + 1) % 8) == 0), "R6 non-bypass still div8", t[0], (((i + 1) % 8) == 0));
    end
  endtask

  task automatic t_gate_off();
    logic [7:0] t;
    wr(5'd0, 32'h0000_0000);             // exponent 0: every strobe
    wr(5'd16, 32'h0000_0000);
    for (int i = 0; i < 4; i++) begin
      stb(1'b1, 1'b1, t);
      check(t == 8'h00, "R5 disabled channels silent", t, 0);
    end
    wr(5'd16, 32'h0000_0001);
    stb(1'b1, 1'b0, t);
    check(t[0] == 1'b1, "R5 re-enabled ticks", t[0], 1);
  endtask

  task automatic t_collide();
    logic [7:0] t;
    wr(5'd16, 32'h0000_0001);
    wr(5'd0, 32'h0000_0002);             // divide by 4
    run_div(2, 1'b0, 0, 4, "R7 pre-count");
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'h0000_0002; osc_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    t = tick_o;
    wr_en = 1'b0; osc_tick = 1'b0;
    check(t[0] == 1'b0, "R7 no tick in write cycle", t[0], 0);
    run_div(8, 1'b0, 0, 4, "R7 restart after collision");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_osc_ratio();
    t_bus_pair();
    t_clamp();
    t_fields();
    t_bypass();
    t_gate_off();
    t_collide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule